// File: doc/BRIEF.md
# Smart Card Transmit Status Flags

This block keeps the three transmit-side status flags of a serial controller that runs in half-duplex smart card mode. These are the data-register-empty flag, the error-signal flag and the transmission-complete flag. It watches the character engine through a few strobes: the end of a character's last bit, the half-bit tick of the bit-rate generator, the receiver's error-signal window and the sampled level of the line inside that window. It then decides when each flag rises and when it falls. Software sees the flags in one status byte. A flag it wants to drop must first be read as 1 and then written as 0.

Transmission-complete is reported a fixed time after each character. The wait is 2.5 bit times in the normal guard mode and 1.0 bit time in the short guard mode. It is reported only when the data register is empty and the card has not signalled an error. While the transmitter is disabled and no error is pending, the flag stays high. A direct-memory-access write into the data register drops both the empty flag and the complete flag. A CPU write into the data register drops only the empty flag.

Top module: `sc_tx_status`

## Requirements
- R1: After reset the status byte reads 0x84. Bit 7 holds the data-register-empty flag (1), bit 4 holds the error-signal flag (0) and bit 2 holds the transmission-complete flag (1). All other bits read 0.
- R2: A cycle with the error window high and the line sampled low sets the error-signal flag, and the flag is visible in the next cycle. A high line in the window sets nothing.
- R3: A write with bit 7 or bit 4 at 0 clears that flag only if a status read since the previous status write returned that flag as 1. Every status write uses up the earlier reads.
- R4: Writing 1 to bit 7 or bit 4 has no effect. Bit 2 cannot be written.
- R5: Changing the transmit enable leaves the error-signal flag unchanged.
- R6: While transmit enable is 0 and the error-signal flag is 0, the transmission-complete flag is set in the next cycle.
- R7: With the guard-mode input at 0, the complete flag is set on the fifth half-bit tick after the end-of-character strobe, and not earlier.
- R8: With the guard-mode input at 1, the complete flag is set on the second half-bit tick after the end-of-character strobe.
- R9: When the delay expires, the complete flag is not set if the error-signal flag is 1 or the data-register-empty flag is 0.
- R10: The complete flag is cleared by a read-then-clear of bit 7 or by a direct-memory-access data write, which also clears bit 7. A CPU data write clears bit 7 only.
- R11: A transfer of data into the shifter sets the empty flag. When a set and a clear condition meet in one cycle, the set wins.
- R12: The low-power stop input returns all flags to the reset state and discards pending reads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low reset |
| lowPowerStop | input | 1 | Standby or module-stop request; forces the reset state |
| halfEtuTick | input | 1 | One pulse per half bit time |
| charDone | input | 1 | End of the last bit of a transmitted character |
| errWindow | input | 1 | Receiver's error-signal sample window |
| guardLine | input | 1 | Sampled line level during the window |
| txEnable | input | 1 | Transmitter enable |
| gmMode | input | 1 | Short guard mode (1.0 bit time delay) |
| txLoad | input | 1 | Data register moved into the shifter |
| tdrWrite | input | 1 | CPU write to the data register |
| dmaTdrWrite | input | 1 | Direct-memory-access write to the data register |
| regRd | input | 1 | Status byte read strobe |
| regWr | input | 1 | Status byte write strobe |
| wrData | input | 8 | Status write data |
| rdData | output | 8 | Status byte |
| tdreFlag | output | 1 | Data-register-empty flag |
| ersFlag | output | 1 | Error-signal flag |
| tendFlag | output | 1 | Transmission-complete indication |

## Verification
The hardest state to reach is a delay that expires while the error-signal flag is pending. The stimulus first raises the error flag through the window strobe, then sends a character end and enough half-bit ticks. The complete flag must stay low. Reaching bare timing checks is also hard, because the complete flag starts at 1 and the disabled transmitter holds it high. So each timing test first enables the transmitter and empties the flag through a read-then-clear. It reloads the empty flag and samples after every single tick, so that an early or late set is seen.

// File: rtl/sctx_pkg.sv
package sctx_pkg;
  localparam int STAT_W   = 8;
  localparam int BIT_TDRE = 7;
  localparam int BIT_ERS  = 4;
  localparam int BIT_TEND = 2;
  localparam int NUM_FLAGS = 3;
  localparam int IDX_TDRE = 0;
  localparam int IDX_ERS  = 1;
  localparam int IDX_TEND = 2;

  typedef struct packed {
    logic setTdre;
    logic clrTdre;
    logic setErs;
    logic clrErs;
    logic setTend;
    logic clrTend;
    logic restore;
  } flagStrobe_t;
endpackage

// File: rtl/sctx_etu_timer.sv
module sctx_etu_timer #(
  parameter int CNT_W = 3,
  parameter int GM0_HALVES = 5,
  parameter int GM1_HALVES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic flush,
  input  logic start,
  input  logic gmMode,
  input  logic halfTick,
  output logic expire
);
  localparam logic [CNT_W-1:0] TGT_GM0 = CNT_W'(GM0_HALVES);
  localparam logic [CNT_W-1:0] TGT_GM1 = CNT_W'(GM1_HALVES);
  localparam logic [CNT_W-1:0] ONE     = CNT_W'(1);

  logic             running;
  logic [CNT_W-1:0] cnt;
  logic [CNT_W-1:0] target;
  logic             lastTick;

  assign lastTick = running && halfTick && ((cnt + ONE) == target);
  assign expire   = lastTick && !start;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      cnt     <= '0;
      target  <= '0;
    end else if (flush) begin
      running <= 1'b0;
      cnt     <= '0;
      target  <= '0;
    end else if (start) begin
      running <= 1'b1;
      cnt     <= '0;
      target  <= gmMode ? TGT_GM1 : TGT_GM0;
    end else if (running && halfTick) begin
      if (lastTick) begin
        running <= 1'b0;
        cnt     <= '0;
      end else begin
        cnt <= cnt + ONE;
      end
    end
  end
endmodule

// File: rtl/sctx_ctrl.sv
module sctx_ctrl
  import sctx_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int GM0_HALVES = 5,
  parameter int GM1_HALVES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPowerStop,
  input  logic              halfEtuTick,
  input  logic              charDone,
  input  logic              errWindow,
  input  logic              guardLine,
  input  logic              txEnable,
  input  logic              gmMode,
  input  logic              txLoad,
  input  logic              tdrWrite,
  input  logic              dmaTdrWrite,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [STAT_W-1:0] wrData,
  input  logic              curTdre,
  input  logic              curErs,
  output flagStrobe_t       strobe
);
  logic seenTdre;
  logic seenErs;
  logic tdreWrClr;
  logic ersWrClr;
  logic delayDone;

  sctx_etu_timer #(
    .CNT_W(CNT_W), .GM0_HALVES(GM0_HALVES), .GM1_HALVES(GM1_HALVES)
  ) uTimer (
    .clk(clk), .rstN(rstN), .flush(lowPowerStop), .start(charDone),
    .gmMode(gmMode), .halfTick(halfEtuTick), .expire(delayDone)
  );

  // Read-as-one latches: a read arms them, any status write disarms them.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seenTdre <= 1'b0;
      seenErs  <= 1'b0;
    end else if (lowPowerStop || regWr) begin
      seenTdre <= 1'b0;
      seenErs  <= 1'b0;
    end else if (regRd) begin
      seenTdre <= seenTdre | curTdre;
      seenErs  <= seenErs  | curErs;
    end
  end

  assign tdreWrClr = regWr && seenTdre && !wrData[BIT_TDRE];
  assign ersWrClr  = regWr && seenErs  && !wrData[BIT_ERS];

  always_comb begin
    strobe         = '0;
    strobe.restore = lowPowerStop;
    strobe.setTdre = txLoad;
    strobe.clrTdre = tdrWrite || dmaTdrWrite || tdreWrClr;
    strobe.setErs  = errWindow && !guardLine;
    strobe.clrErs  = ersWrClr;
    strobe.setTend = !curErs && ((!txEnable) || (delayDone && curTdre));
    strobe.clrTend = tdreWrClr || dmaTdrWrite;
  end
endmodule

// File: rtl/sctx_flags.sv
module sctx_flags
  import sctx_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  flagStrobe_t strobe,
  output logic        tdre,
  output logic        ers,
  output logic        tend
);
  localparam logic [NUM_FLAGS-1:0] RESET_VAL = NUM_FLAGS'(3'b101);

  logic [NUM_FLAGS-1:0] setVec;
  logic [NUM_FLAGS-1:0] clrVec;
  logic [NUM_FLAGS-1:0] flagQ;

  always_comb begin
    setVec = '0;
    clrVec = '0;
    setVec[IDX_TDRE] = strobe.setTdre;
    clrVec[IDX_TDRE] = strobe.clrTdre;
    setVec[IDX_ERS]  = strobe.setErs;
    clrVec[IDX_ERS]  = strobe.clrErs;
    setVec[IDX_TEND] = strobe.setTend;
    clrVec[IDX_TEND] = strobe.clrTend;
  end

  for (genvar i = 0; i < NUM_FLAGS; i++) begin : gFlag
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN)              flagQ[i] <= RESET_VAL[i];
      else if (strobe.restore) flagQ[i] <= RESET_VAL[i];
      else if (setVec[i])     flagQ[i] <= 1'b1;
      else if (clrVec[i])     flagQ[i] <= 1'b0;
    end
  end

  assign tdre = flagQ[IDX_TDRE];
  assign ers  = flagQ[IDX_ERS];
  assign tend = flagQ[IDX_TEND];
endmodule

// File: rtl/sc_tx_status.sv
module sc_tx_status
  import sctx_pkg::*;
#(
  parameter int CNT_W = 3,
  parameter int GM0_HALVES = 5,
  parameter int GM1_HALVES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              lowPowerStop,
  input  logic              halfEtuTick,
  input  logic              charDone,
  input  logic              errWindow,
  input  logic              guardLine,
  input  logic              txEnable,
  input  logic              gmMode,
  input  logic              txLoad,
  input  logic              tdrWrite,
  input  logic              dmaTdrWrite,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [STAT_W-1:0] wrData,
  output logic [STAT_W-1:0] rdData,
  output logic              tdreFlag,
  output logic              ersFlag,
  output logic              tendFlag
);
  flagStrobe_t strobe;

  sctx_ctrl #(
    .CNT_W(CNT_W), .GM0_HALVES(GM0_HALVES), .GM1_HALVES(GM1_HALVES)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .lowPowerStop(lowPowerStop),
    .halfEtuTick(halfEtuTick), .charDone(charDone), .errWindow(errWindow),
    .guardLine(guardLine), .txEnable(txEnable), .gmMode(gmMode),
    .txLoad(txLoad), .tdrWrite(tdrWrite), .dmaTdrWrite(dmaTdrWrite),
    .regRd(regRd), .regWr(regWr), .wrData(wrData),
    .curTdre(tdreFlag), .curErs(ersFlag), .strobe(strobe)
  );

  sctx_flags uFlags (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .tdre(tdreFlag), .ers(ersFlag), .tend(tendFlag)
  );

  always_comb begin
    rdData           = '0;
    rdData[BIT_TDRE] = tdreFlag;
    rdData[BIT_ERS]  = ersFlag;
    rdData[BIT_TEND] = tendFlag;
  end
endmodule

// File: rtl/sc_tx_status_chk.sv
module sc_tx_status_chk (
  input logic       clk,
  input logic       rstN,
  input logic       lowPowerStop,
  input logic       errWindow,
  input logic       guardLine,
  input logic       txEnable,
  input logic       tdrWrite,
  input logic       dmaTdrWrite,
  input logic       txLoad,
  input logic       regWr,
  input logic [7:0] wrData,
  input logic       tdreFlag,
  input logic       ersFlag,
  input logic       tendFlag
);
  AST_ERS_SET: assert property (@(posedge clk) disable iff (!rstN)
    (errWindow && !guardLine && !lowPowerStop) |=> ersFlag); // R2

  AST_ERS_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (!(errWindow && !guardLine) && !regWr && !lowPowerStop) |=> $stable(ersFlag)); // R5

  AST_TEND_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    (!txEnable && !ersFlag && !lowPowerStop) |=> tendFlag); // R6

  AST_TDR_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    ((tdrWrite || dmaTdrWrite) && !txLoad && !lowPowerStop) |=> !tdreFlag); // R10

  AST_WRITE_ONE: assert property (@(posedge clk) disable iff (!rstN)
    (regWr && wrData[7] && tdreFlag && !tdrWrite && !dmaTdrWrite && !lowPowerStop)
      |=> tdreFlag); // R4

  AST_STOP_RESTORE: assert property (@(posedge clk) disable iff (!rstN)
    lowPowerStop |=> (tdreFlag && tendFlag && !ersFlag)); // R12
endmodule

bind sc_tx_status sc_tx_status_chk uChk (
  .clk(clk), .rstN(rstN), .lowPowerStop(lowPowerStop), .errWindow(errWindow),
  .guardLine(guardLine), .txEnable(txEnable), .tdrWrite(tdrWrite),
  .dmaTdrWrite(dmaTdrWrite), .txLoad(txLoad), .regWr(regWr), .wrData(wrData),
  .tdreFlag(tdreFlag), .ersFlag(ersFlag), .tendFlag(tendFlag)
);

// File: tb/tb_sc_tx_status.sv
`timescale 1ns/1ps
module tb_sc_tx_status;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic lowPowerStop = 0, halfEtuTick = 0, charDone = 0, errWindow = 0;
  logic guardLine = 1, txEnable = 1, gmMode = 0, txLoad = 0;
  logic tdrWrite = 0, dmaTdrWrite = 0, regRd = 0, regWr = 0;
  logic [7:0] wrData = 8'h00;
  logic [7:0] rdData;
  logic tdreFlag, ersFlag, tendFlag;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #4 clk = ~clk; // 125 MHz

  sc_tx_status dut (
    .clk(clk), .rstN(rstN), .lowPowerStop(lowPowerStop),
    .halfEtuTick(halfEtuTick), .charDone(charDone), .errWindow(errWindow),
    .guardLine(guardLine), .txEnable(txEnable), .gmMode(gmMode),
    .txLoad(txLoad), .tdrWrite(tdrWrite), .dmaTdrWrite(dmaTdrWrite),
    .regRd(regRd), .regWr(regWr), .wrData(wrData), .rdData(rdData),
    .tdreFlag(tdreFlag), .ersFlag(ersFlag), .tendFlag(tendFlag)
  );

  task automatic chk(input string req, input logic [7:0] exp);
    checks++;
    if (rdData !== exp) begin
      errors++;
      $display("FAIL %s: status actual=%02h expected=%02h", req, rdData, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1; step(); s = 1'b0;
  endtask

  task automatic statusRead();
    regRd = 1'b1; step(); regRd = 1'b0;
  endtask

  task automatic statusWrite(input logic [7:0] d);
    wrData = d; regWr = 1'b1; step(); regWr = 1'b0; wrData = 8'h00;
  endtask

  task automatic halfTicks(input int n);
    for (int i = 0; i < n; i++) begin
      pulse(halfEtuTick); step();
    end
  endtask

  task automatic t_reset();
    chk("R1 reset state", 8'h84);
  endtask

  task automatic t_write_rules();
    statusWrite(8'h00);
    chk("R3 write 0 without read", 8'h84);
    statusRead();
    statusWrite(8'hFF);
    chk("R4 write 1 ignored", 8'h84);
    statusWrite(8'h00);
    chk("R3 read used up by prior write", 8'h84);
    statusRead();
    statusWrite(8'h00);
    chk("R10 read-then-clear drops empty and complete", 8'h00);
  endtask

  task automatic t_load();
    pulse(txLoad);
    chk("R11 shifter load sets empty flag", 8'h80);
    pulse(tdrWrite);
    chk("R10 CPU data write clears empty only", 8'h00);
    txLoad = 1'b1; tdrWrite = 1'b1; step(); txLoad = 1'b0; tdrWrite = 1'b0;
    chk("R11 set wins over clear", 8'h80);
  endtask

  task automatic t_gm0();
    gmMode = 1'b0;
    pulse(charDone);
    halfTicks(4);
    chk("R7 not set after four half ticks", 8'h80);
    halfTicks(1);
    chk("R7 set after fifth half tick", 8'h84);
    pulse(dmaTdrWrite);
    chk("R10 DMA write clears empty and complete", 8'h00);
    pulse(txLoad);
  endtask

  task automatic t_gm1();
    gmMode = 1'b1;
    pulse(charDone);
    halfTicks(1);
    chk("R8 not set after one half tick", 8'h80);
    halfTicks(1);
    chk("R8 set after second half tick", 8'h84);
    pulse(dmaTdrWrite);
    pulse(txLoad);
    chk("R11 reload before error test", 8'h80);
  endtask

  task automatic t_ers();
    errWindow = 1'b1; guardLine = 1'b1; step(); errWindow = 1'b0;
    chk("R2 high line sets nothing", 8'h80);
    errWindow = 1'b1; guardLine = 1'b0; step(); errWindow = 1'b0; guardLine = 1'b1;
    chk("R2 low line sets error flag", 8'h90);
    gmMode = 1'b1;
    pulse(charDone);
    halfTicks(2);
    chk("R9 no complete with error pending", 8'h90);
    txEnable = 1'b0; step(); step();
    chk("R5 disable keeps error flag", 8'h90);
    txEnable = 1'b1; step();
    statusWrite(8'h00);
    chk("R3 error kept without read", 8'h90);
    statusRead();
    statusWrite(8'hEF);
    chk("R3 read-then-clear drops error only", 8'h80);
    pulse(tdrWrite);
    pulse(charDone);
    halfTicks(2);
    chk("R9 no complete with data register full", 8'h00);
  endtask

  task automatic t_idle();
    txEnable = 1'b0; step();
    chk("R6 disabled transmitter sets complete", 8'h04);
  endtask

  task automatic t_stop();
    errWindow = 1'b1; guardLine = 1'b0; step(); errWindow = 1'b0; guardLine = 1'b1;
    chk("R2 error flag set before stop", 8'h14);
    statusRead();
    pulse(lowPowerStop);
    chk("R12 stop restores reset state", 8'h84);
    txEnable = 1'b1;
    statusWrite(8'h00);
    chk("R12 pending read discarded", 8'h84);
  endtask

  initial begin
    fork
      begin
        step(); step();
        rstN = 1'b1;
        step();
        t_reset();
        t_write_rules();
        t_load();
        t_gm0();
        t_gm1();
        t_ers();
        t_idle();
        t_stop();
        done = 1;
      end
      begin
        repeat (20000) @(posedge clk);
        if (!done) begin
          checks++; errors++;
          $display("FAIL watchdog: actual=hung expected=finished");
        end
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule